// File: doc/BRIEF.md
# Edge-Selected Input Capture with Lockout

This block watches an asynchronous input pin for a chosen transition: rising, falling or either. When that transition is seen, it copies the value of an external 16-bit free-running counter into a capture register and raises an edge flag. While the flag is raised the capture register is frozen, and later transitions on the pin leave it alone. Software reads the captured timestamp and then releases the lock by writing zero to the flag.

The pin first passes through a synchronizer. Transitions are found by comparing the synchronized level with its level one clock earlier. A two-bit select field chooses the transition, and one of its codes turns capture off. A flag write that carries a one does nothing. If a clearing write lands in the same clock as a qualifying transition, the transition wins: the new count is taken and the flag stays up.

Top module: `edge_capture_lock`

## Requirements
- R1: With `edge_sel` = 2'b01, a low-to-high pin transition loads `count_in` into `cap_value` and sets `cap_flag`. A high-to-low transition is ignored.
- R2: With `edge_sel` = 2'b10, a high-to-low pin transition captures and sets the flag. A low-to-high transition is ignored.
- R3: With `edge_sel` = 2'b11, transitions in either direction capture and set the flag.
- R4: With `edge_sel` = 2'b00, no transition changes `cap_value` or `cap_flag`.
- R5: While `cap_flag` is 1 and no clearing write occurs, further qualifying transitions leave `cap_value` unchanged and the flag stays 1.
- R6: A write (`flag_wr` = 1, `flag_wdata` = 0) clears `cap_flag` on the next clock edge when no qualifying transition occurs in that clock. After that, the next qualifying transition captures again.
- R7: A write with `flag_wdata` = 1 has no effect on `cap_flag` or `cap_value`.
- R8: When a clearing write and a qualifying transition fall in the same clock, `cap_value` takes `count_in` and `cap_flag` remains 1.
- R9: A pin level first sampled at clock edge k is detected as a transition in the cycle after edge k+1. `cap_value` and `cap_flag` update at edge k+2 with the `count_in` present at that edge.
- R10: Reset (`rst_n` low, asynchronous) sets `cap_value`, `cap_flag` and the synchronizer stages to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | External input, not synchronized to clk |
| edge_sel | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| count_in | input | CNT_W | Free-running counter value to capture |
| flag_wr | input | 1 | Write strobe for the edge flag |
| flag_wdata | input | 1 | Data written to the flag; only 0 acts |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Edge flag; 1 means capture is locked |

## Verification
The bench goes after the lock and the write-priority corners. A design that kept overwriting would report the count of the last transition instead of the first one. A design that let a clearing write beat a same-clock transition would drop that capture and leave the flag low. A write of one is checked so that a design treating any write as a clear would lose the lock. The latency test changes `count_in` on every cycle around the transition, so a capture taken one cycle early or late shows up as a wrong timestamp.

// File: rtl/edge_capture_lock.sv
`timescale 1ns/1ps
module edge_capture_lock #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_async,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] count_in,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;
  logic            lvl, lvl_q, rise, fall, hit, clr, take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], pin_async};

  assign lvl   = sh[SH_W-2];
  assign lvl_q = sh[SH_W-1];
  assign rise  = lvl & ~lvl_q;
  assign fall  = ~lvl & lvl_q;
  assign hit   = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  assign clr   = flag_wr & ~flag_wdata;
  assign take  = hit & (~cap_flag | clr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else if (take) begin
      cap_value <= count_in;
      cap_flag  <= 1'b1;
    end else if (clr) begin
      cap_flag  <= 1'b0;
    end

endmodule

// File: rtl/edge_capture_lock_chk.sv
`timescale 1ns/1ps
module edge_capture_lock_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       edge_sel,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag
);

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !flag_wr |=> $stable(cap_value) && cap_flag); // R5

  AST_CAP_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> cap_flag); // R5

  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    edge_sel == 2'b00 && !cap_flag |=> !cap_flag && $stable(cap_value)); // R4

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr && !flag_wdata && edge_sel == 2'b00 |=> !cap_flag); // R6

  AST_WRITE_ONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr && flag_wdata && cap_flag |=> cap_flag && $stable(cap_value)); // R7

  always @(posedge clk)
    if (!rst_n) AST_RESET_ZERO: assert (cap_value == '0 && !cap_flag); // R10

endmodule

bind edge_capture_lock edge_capture_lock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .flag_wr(flag_wr),
  .flag_wdata(flag_wdata), .cap_value(cap_value), .cap_flag(cap_flag)
);

// File: tb/edge_capture_lock_bench.sv
`timescale 1ns/1ps
module edge_capture_lock_bench;
  localparam int W = 16;

  logic         clk = 0, rst_n = 0, pin = 0, fwr = 0, fwd = 0;
  logic [1:0]   sel = 0;
  logic [W-1:0] cnt = 0, cap;
  logic         flag;
  int           checks = 0, errors = 0;
  logic [W-1:0] exp_cap = 0;

  always #10 clk = ~clk;

  edge_capture_lock u_edge_capture_lock (
    .clk(clk), .rst_n(rst_n), .pin_async(pin), .edge_sel(sel), .count_in(cnt),
    .flag_wr(fwr), .flag_wdata(fwd), .cap_value(cap), .cap_flag(flag)
  );

  // {sel[1:0], pin_start, pin_end, expect_capture, count[15:0]}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b1, 1'b1, 16'hA001},
    {2'b01, 1'b1, 1'b0, 1'b0, 16'hA002},
    {2'b10, 1'b1, 1'b0, 1'b1, 16'hB003},
    {2'b10, 1'b0, 1'b1, 1'b0, 16'hB004},
    {2'b11, 1'b0, 1'b1, 1'b1, 16'hC005},
    {2'b11, 1'b1, 1'b0, 1'b1, 16'hC006},
    {2'b00, 1'b0, 1'b1, 1'b0, 16'hD007},
    {2'b00, 1'b1, 1'b0, 1'b0, 16'hD008}
  };

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'b01:   return "R1";
      2'b10:   return "R2";
      2'b11:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    fwr = 1; fwd = 0; step(1); fwr = 0;
  endtask

  task automatic edge_to(input logic lvl);
    pin = lvl; step(4);
  endtask

  initial begin
    step(3);
    check(cap == 0, "R10 reset cap", cap, 0);
    check(flag == 0, "R10 reset flag", flag, 0);
    rst_n = 1; step(2);

    for (int i = 0; i < NV; i++) begin
      sel = 2'b00; pin = VEC[i][18]; step(4);
      clear_flag();
      check(flag == 0, "R6 clear before vector", flag, 0);
      sel = VEC[i][20:19]; cnt = VEC[i][15:0]; pin = VEC[i][17]; step(4);
      if (VEC[i][16]) exp_cap = VEC[i][15:0];
      check(flag == VEC[i][16], sel_tag(VEC[i][20:19]), flag, VEC[i][16]);
      check(cap == exp_cap, sel_tag(VEC[i][20:19]), cap, exp_cap);
    end

    // R5 lockout: first capture stays
    sel = 2'b00; pin = 0; step(4); clear_flag();
    sel = 2'b11; cnt = 16'h1111; edge_to(1);
    exp_cap = 16'h1111;
    cnt = 16'h2222; edge_to(0);
    cnt = 16'h3333; edge_to(1);
    check(flag == 1, "R5 flag held", flag, 1);
    check(cap == exp_cap, "R5 lockout", cap, exp_cap);

    // R7 write of one does nothing
    fwr = 1; fwd = 1; step(1); fwr = 0;
    check(flag == 1, "R7 flag after write 1", flag, 1);
    cnt = 16'h4444; edge_to(0);
    check(cap == exp_cap, "R7 still locked", cap, exp_cap);

    // R6 clear then new capture
    clear_flag();
    check(flag == 0, "R6 flag cleared", flag, 0);
    cnt = 16'h5555; edge_to(1); exp_cap = 16'h5555;
    check(cap == exp_cap && flag, "R6 recapture", cap, exp_cap);

    // R8 same-clock edge and clear: edge wins
    pin = 0; cnt = 16'h6666; step(2);
    fwr = 1; fwd = 0; cnt = 16'h7777; step(1); fwr = 0;
    exp_cap = 16'h7777;
    check(flag == 1, "R8 flag stays set", flag, 1);
    check(cap == exp_cap, "R8 edge wins", cap, exp_cap);

    // R9 latency: pin sampled at edge k, capture at edge k+2
    sel = 2'b01; step(2); clear_flag();
    cnt = 16'h0A0A; pin = 1; step(1);
    cnt = 16'h0B0B; step(1);
    check(flag == 0, "R9 no capture at k+1", flag, 0);
    cnt = 16'h0C0C; step(1);
    exp_cap = 16'h0C0C;
    check(flag == 1, "R9 flag at k+2", flag, 1);
    check(cap == exp_cap, "R9 count at k+2", cap, exp_cap);

    // R10 reset mid-run
    sel = 2'b00; rst_n = 0; step(2);
    check(cap == 0 && flag == 0, "R10 reset mid-run", {cap, 15'b0, flag}, 0);
    pin = 0; rst_n = 1; step(4);
    sel = 2'b10; cnt = 16'h0E0E; edge_to(1);
    check(flag == 0, "R10 sync cleared, rising ignored", flag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule